// File: doc/BRIEF.md
# Dual-Channel Serial DAC Control Logic

This block is the digital front end of a two-channel voltage-output converter. A host sends 32-bit command words over a three-wire serial link made of a clock, a data line and an active-low frame strobe. The block decodes each complete word into a command, a channel address and a 16-bit data value. Each channel keeps two registers. The staging register receives new data. The output register drives the code that goes to the analog converter. A new value reaches the output only when it is moved from the staging register to the output register. That move happens through a serial update command or through a falling edge on the hardware load pin.

The hardware load pin can be masked per channel. A falling edge on the clear pin forces every staging and output register to a selectable clear code. Each channel has a 2-bit power-down mode, and a lockout pin prevents any serial command from entering power-down. At reset, the outputs start at zero or at midscale, depending on a strap pin. An optional cascade mode sends the shifted-out word on the serial output so that several devices can share one link.

All pins are sampled in the system clock domain through two-stage synchronizers. The serial clock must therefore stay below one quarter of the system clock rate.

Top module: `dual_dac_ctrl`

## Requirements
- R1: In reset and after it, both output codes equal 0x8000 when `mid_strap` is 1 and 0x0000 when it is 0. Both power-down fields are 00 and `sdo` is 0.
- R2: Command 0 writes the data field (word bits 19:4) into the staging register of the addressed channel. The output codes do not change.
- R3: Command 1 copies the staging register into the output register of the addressed channel.
- R4: Command 3 writes the data into both the staging and the output register of the addressed channel. Address 0 selects channel A, address 1 selects channel B and address 0xF selects both. The address sits in word bits 23:20 and the command in bits 27:24.
- R5: Command 2 writes the staging register of the addressed channel and then copies the staging registers of both channels into their output registers.
- R6: A word is executed only when exactly 32 serial-clock falling edges occur while the strobe is low. Words with 31 or 33 edges are discarded.
- R7: A falling edge on `ldac_n` copies the staging register to the output register for every channel that has pending data and whose mask bit is 0. Command 5 sets the mask from word bits 1:0, where bit 0 is channel A and bit 1 is channel B.
- R8: A falling edge on `clr_n` loads the clear code into the staging and output registers of both channels. Command 6 sets the clear-code field from word bits 1:0: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF and 11 gives 0x0000.
- R9: Command 4 writes the mode in word bits 9:8 into the power-down field of each channel whose select bit is set. Bit 0 selects A and bit 1 selects B.
- R10: While `pd_lock` is high, a command 4 word with a nonzero mode changes nothing. A mode of 00 is still applied.
- R11: Command 8 sets cascade mode from word bit 0. In cascade mode, `sdo` carries the previous word, MSB first, while the next word is shifted in. Outside cascade mode, `sdo` stays 0.
- R12: Data commands (0 to 3) that carry an address other than 0, 1 or 0xF are ignored.
- R13: Word bits 31:28 have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mid_strap | input | 1 | Reset value select: 1 gives midscale, 0 gives zero |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame strobe |
| din | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Hardware load; acts on its falling edge |
| clr_n | input | 1 | Clear; acts on its falling edge |
| pd_lock | input | 1 | Blocks serial entry into power-down |
| sdo | output | 1 | Cascade serial output |
| code_a | output | 16 | Output register of channel A |
| code_b | output | 16 | Output register of channel B |
| pd_a | output | 2 | Power-down mode of channel A |
| pd_b | output | 2 | Power-down mode of channel B |

## Verification
The update path is exercised with several word patterns. A staging-only write followed by a separate update shows that the two registers are distinct. Single, both-channel and invalid addresses show the channel decode. A write-and-update-all with the other channel still pending checks the broadcast copy. Words of 31 and 33 bits, and a word with junk in its top nibble, check the framing rule. Hardware load pulses under two different masks show which channels honour the pin. Clear pulses under each clear code, and each power-down mode with the lockout high and low, tell the code and mode paths apart. The cascade output is compared bit by bit with the word sent before it.

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mid_strap,
  input  logic          sclk,
  input  logic          sync_n,
  input  logic          din,
  input  logic          ldac_n,
  input  logic          clr_n,
  input  logic          pd_lock,
  output logic          sdo,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic [1:0]    pd_a,
  output logic [1:0]    pd_b
);
  localparam int FW   = 32;
  localparam int CW   = $clog2(FW + 2);
  localparam int DLO  = 4;
  localparam logic [CW-1:0] CMAX = CW'(FW + 1);

  logic [2:0] sclk_q, sync_q, ldac_q, clr_q;
  logic [1:0] din_q, lock_q;
  logic [FW-1:0] sr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] stg [2];
  logic [DW-1:0] dac [2];
  logic [1:0] pd [2];
  logic [1:0] pend, mask, ccode;
  logic dcen;

  wire sclk_fall = sclk_q[2] & ~sclk_q[1];
  wire in_frame  = ~sync_q[1];
  wire sync_rise = ~sync_q[2] & sync_q[1];
  wire ldac_fall = ldac_q[2] & ~ldac_q[1];
  wire clr_fall  = clr_q[2] & ~clr_q[1];
  wire lock_s    = lock_q[1];
  wire exec      = sync_rise && (cnt == CW'(FW));

  wire [3:0]    cmd  = sr[27:24];
  wire [3:0]    addr = sr[23:20];
  wire [DW-1:0] data = sr[DLO+DW-1:DLO];
  wire [1:0]    mode = sr[9:8];
  wire [1:0]    sel  = {addr == 4'h1 || addr == 4'hF, addr == 4'h0 || addr == 4'hF};
  wire          addr_ok = |sel;
  wire [DW-1:0] rst_code = mid_strap ? DW'(1) << (DW-1) : '0;

  logic [DW-1:0] clr_val;
  always_comb begin
    case (ccode)
      2'b01:   clr_val = DW'(1) << (DW-1);
      2'b10:   clr_val = '1;
      default: clr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '1; sync_q <= '1; ldac_q <= '1; clr_q <= '1;
      din_q  <= '0; lock_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      sync_q <= {sync_q[1:0], sync_n};
      ldac_q <= {ldac_q[1:0], ldac_n};
      clr_q  <= {clr_q[1:0], clr_n};
      din_q  <= {din_q[0], din};
      lock_q <= {lock_q[0], pd_lock};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (!in_frame) begin
      cnt <= '0;
    end else if (sclk_fall) begin
      sr  <= {sr[FW-2:0], din_q[1]};
      cnt <= (cnt == CMAX) ? CMAX : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        stg[i] <= rst_code;
        dac[i] <= rst_code;
        pd[i]  <= 2'b00;
      end
      pend  <= '0;
      mask  <= '0;
      ccode <= '0;
      dcen  <= 1'b0;
    end else if (clr_fall) begin
      for (int i = 0; i < 2; i++) begin
        stg[i] <= clr_val;
        dac[i] <= clr_val;
      end
      pend <= '0;
    end else begin
      if (ldac_fall) begin
        for (int i = 0; i < 2; i++) begin
          if (pend[i] && !mask[i]) begin
            dac[i]  <= stg[i];
            pend[i] <= 1'b0;
          end
        end
      end
      if (exec) begin
        case (cmd)
          4'h0: if (addr_ok) begin
            for (int i = 0; i < 2; i++) begin
              if (sel[i]) begin
                stg[i]  <= data;
                pend[i] <= 1'b1;
              end
            end
          end
          4'h1: if (addr_ok) begin
            for (int i = 0; i < 2; i++) begin
              if (sel[i]) begin
                dac[i]  <= stg[i];
                pend[i] <= 1'b0;
              end
            end
          end
          4'h2: if (addr_ok) begin
            for (int i = 0; i < 2; i++) begin
              if (sel[i]) begin
                stg[i] <= data;
                dac[i] <= data;
              end else begin
                dac[i] <= stg[i];
              end
            end
            pend <= '0;
          end
          4'h3: if (addr_ok) begin
            for (int i = 0; i < 2; i++) begin
              if (sel[i]) begin
                stg[i]  <= data;
                dac[i]  <= data;
                pend[i] <= 1'b0;
              end
            end
          end
          4'h4: if (!(lock_s && mode != 2'b00)) begin
            for (int i = 0; i < 2; i++) begin
              if (sr[i]) pd[i] <= mode;
            end
          end
          4'h5: mask  <= sr[1:0];
          4'h6: ccode <= sr[1:0];
          4'h8: dcen  <= sr[0];
          default: ;
        endcase
      end
    end
  end

  assign sdo    = dcen & sr[FW-1];
  assign code_a = dac[0];
  assign code_b = dac[1];
  assign pd_a   = pd[0];
  assign pd_b   = pd[1];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec && !clr_fall && !ldac_fall) |=> ($stable(code_a) && $stable(code_b)));

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);

  p_ldac_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fall && !clr_fall && !exec) |=> ((pend & ~mask) == 2'b00));

  p_clr_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (code_a == code_b && pend == 2'b00));

  p_lock_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_s && pd_a == 2'b00) |=> pd_a == 2'b00);

  p_lock_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_s && pd_b == 2'b00) |=> pd_b == 2'b00);
endmodule

// File: tb/dual_dac_ctrl_bench.sv
module dual_dac_ctrl_bench;
  logic clk = 0, rst_n = 0, mid_strap = 1;
  logic sclk = 1, sync_n = 1, din = 0, ldac_n = 1, clr_n = 1, pd_lock = 0;
  logic sdo;
  logic [15:0] code_a, code_b;
  logic [1:0] pd_a, pd_b;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_dac_ctrl u_dual_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .mid_strap(mid_strap), .sclk(sclk), .sync_n(sync_n),
    .din(din), .ldac_n(ldac_n), .clr_n(clr_n), .pd_lock(pd_lock), .sdo(sdo),
    .code_a(code_a), .code_b(code_b), .pd_a(pd_a), .pd_b(pd_b));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] w(logic [3:0] cmd, logic [3:0] adr, logic [15:0] d);
    return {4'h0, cmd, adr, d, 4'h0};
  endfunction

  task automatic send(logic [31:0] word, int nbits);
    @(negedge clk); sync_n = 0; waitc(4);
    for (int k = 0; k < nbits; k++) begin
      din = (k < 32) ? word[31-k] : 1'b0;
      sclk = 1; waitc(4);
      sclk = 0; waitc(4);
    end
    sclk = 1; waitc(4);
    sync_n = 1; waitc(10);
  endtask

  task automatic pulse_ldac();
    @(negedge clk); ldac_n = 0; waitc(4); ldac_n = 1; waitc(6);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_n = 0; waitc(4); clr_n = 1; waitc(6);
  endtask

  task automatic do_reset(logic mid);
    mid_strap = mid; rst_n = 0; waitc(5);
    chk("R1 code_a in reset", code_a, mid ? 16'h8000 : 16'h0000);
    rst_n = 1; waitc(3);
    chk("R1 code_a", code_a, mid ? 16'h8000 : 16'h0000);
    chk("R1 code_b", code_b, mid ? 16'h8000 : 16'h0000);
    chk("R1 pd", {12'h0, pd_a, pd_b}, 16'h0);
    chk("R1 sdo", {15'h0, sdo}, 16'h0);
  endtask

  task automatic t_write_then_update();
    send(w(4'h0, 4'h0, 16'h1234), 32);
    chk("R2 code_a after staging write", code_a, 16'h0000);
    send(w(4'h1, 4'h0, 16'h0000), 32);
    chk("R3 code_a after update", code_a, 16'h1234);
    chk("R3 code_b untouched", code_b, 16'h0000);
  endtask

  task automatic t_write_update();
    send(w(4'h3, 4'h1, 16'hBEEF), 32);
    chk("R4 code_b single", code_b, 16'hBEEF);
    chk("R4 code_a untouched", code_a, 16'h1234);
    send(w(4'h3, 4'hF, 16'h5555), 32);
    chk("R4 code_a both", code_a, 16'h5555);
    chk("R4 code_b both", code_b, 16'h5555);
  endtask

  task automatic t_update_all();
    send(w(4'h0, 4'h0, 16'h1111), 32);
    send(w(4'h2, 4'h1, 16'h2222), 32);
    chk("R5 code_a broadcast", code_a, 16'h1111);
    chk("R5 code_b written", code_b, 16'h2222);
  endtask

  task automatic t_framing();
    send(w(4'h3, 4'h0, 16'h7777), 31);
    chk("R6 31-bit word ignored", code_a, 16'h1111);
    send(w(4'h3, 4'h0, 16'h7777), 33);
    chk("R6 33-bit word ignored", code_a, 16'h1111);
    send(w(4'h3, 4'h2, 16'h9999), 32);
    chk("R12 bad address a", code_a, 16'h1111);
    chk("R12 bad address b", code_b, 16'h2222);
    send({4'hF, 4'h3, 4'h0, 16'h4242, 4'h0}, 32);
    chk("R13 top nibble ignored", code_a, 16'h4242);
  endtask

  task automatic t_ldac();
    send({28'h0500000, 4'h2}, 32);
    send(w(4'h0, 4'h0, 16'hA0A0), 32);
    send(w(4'h0, 4'h1, 16'hB0B0), 32);
    pulse_ldac();
    chk("R7 unmasked a loads", code_a, 16'hA0A0);
    chk("R7 masked b holds", code_b, 16'h2222);
    send({28'h0500000, 4'h0}, 32);
    pulse_ldac();
    chk("R7 unmasked b loads", code_b, 16'hB0B0);
  endtask

  task automatic t_clear();
    send({28'h0600000, 4'h1}, 32);
    send(w(4'h0, 4'h1, 16'h6666), 32);
    pulse_clr();
    chk("R8 clr mid a", code_a, 16'h8000);
    chk("R8 clr mid b", code_b, 16'h8000);
    send(w(4'h1, 4'hF, 16'h0000), 32);
    chk("R8 staging also cleared", code_b, 16'h8000);
    send({28'h0600000, 4'h2}, 32);
    pulse_clr();
    chk("R8 clr full", code_a, 16'hFFFF);
    send({28'h0600000, 4'h0}, 32);
    pulse_clr();
    chk("R8 clr zero", code_b, 16'h0000);
  endtask

  task automatic t_power();
    send({28'h0400020, 4'h1}, 32);
    chk("R9 pd_a mode 10", {14'h0, pd_a}, 16'h2);
    chk("R9 pd_b untouched", {14'h0, pd_b}, 16'h0);
    send({28'h0400030, 4'h3}, 32);
    chk("R9 pd both 11", {12'h0, pd_a, pd_b}, 16'hF);
    pd_lock = 1;
    send({28'h0400000, 4'h3}, 32);
    chk("R10 mode 00 under lock", {12'h0, pd_a, pd_b}, 16'h0);
    send({28'h0400010, 4'h1}, 32);
    chk("R10 power-down blocked", {14'h0, pd_a}, 16'h0);
    pd_lock = 0;
  endtask

  task automatic t_daisy();
    logic [31:0] prev, got;
    send(w(4'h3, 4'h0, 16'hC3A5), 32);
    chk("R11 sdo low when disabled", {15'h0, sdo}, 16'h0);
    send({28'h0800000, 4'h1}, 32);
    prev = w(4'h0, 4'h1, 16'h5AC3);
    send(prev, 32);
    @(negedge clk); sync_n = 0; waitc(4);
    for (int k = 0; k < 32; k++) begin
      din = 1'b0;
      sclk = 1; waitc(4);
      got[31-k] = sdo;
      sclk = 0; waitc(4);
    end
    sclk = 1; waitc(4); sync_n = 1; waitc(10);
    chk("R11 sdo upper half", got[31:16], prev[31:16]);
    chk("R11 sdo lower half", got[15:0], prev[15:0]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    do_reset(1'b0);
    t_write_then_update();
    t_write_update();
    t_update_all();
    t_framing();
    t_ldac();
    t_clear();
    t_power();
    t_daisy();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule